// File: doc/BRIEF.md
# Checked Load/Store Memory Port

This block sits between a processor core's load/store path and a word-wide, byte-addressed RAM of configurable size. The core presents one request per cycle: an address, an access size (byte, halfword or word), a write flag and write data. The block checks the request before it drives the RAM. A legal request becomes a RAM access with per-byte write enables. An illegal one produces a fault code, and the RAM is not touched at all.

The byte order is set by a static configuration input. With big-endian order the byte at the lowest address is the most significant byte of a halfword or word. With little-endian order it is the least significant byte. Inside a RAM word, byte lane k (data bits 8k+7:8k) always holds the byte at word address ×4 + k, whatever the configured order. The RAM reads with one cycle of latency, and each request gets its response one clock after it is accepted.

Two states make up the control: `ST_IDLE` (no response due) and `ST_RESP` (a response is on the outputs this cycle). The transitions are:
- *accept* (ST_IDLE→ST_RESP, when a request is valid).
- *stream* (ST_RESP→ST_RESP, when another request is valid).
- *drain* (ST_RESP→ST_IDLE, when no request is valid).
- *wait* (ST_IDLE→ST_IDLE, when no request is valid).

Top module: `ckmem_port`

## Requirements
- R1: A request whose unsigned address is greater than or equal to MEM_BYTES (default 2^23) gets fault code 01. For that request ram_en and ram_we stay 0.
- R2: A word request with address bits 1:0 not 00, or a halfword request with address bit 0 set, gets fault code 10, and the RAM is not accessed. A byte request never gets fault 10.
- R3: When an address is both out of range and misaligned, only the range code 01 is reported.
- R4: When big_endian is 1, the byte at the lowest address is the most significant byte of a halfword or word, for both reads and writes.
- R5: When big_endian is 0, the byte at the lowest address is the least significant byte of a halfword or word, for both reads and writes.
- R6: Byte and halfword reads are zero-extended to 32 bits on rsp_rdata.
- R7: A faulting read returns zero data. Every write response also carries zero data.
- R8: rsp_valid is high exactly one clock after each cycle with req_valid high, and low otherwise. rsp_fault and rsp_rdata belong to that request. Back-to-back requests are supported.
- R9: A byte write takes only req_wdata[7:0] and sets one write enable, bit addr[1:0]. A halfword write takes only req_wdata[15:0] and sets enables 0011 (addr[1]=0) or 1100 (addr[1]=1). A word write sets 1111.
- R10: After reset, rsp_valid is 0, and ram_en and ram_we are 0 while no request is valid.
- R11: Size code 11 behaves exactly as a word access (00 byte, 01 halfword, 10 word). Fault code 00 means no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | Static byte order select: 1 big-endian, 0 little-endian |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_we | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_rdata | output | 32 | Zero-extended read data; zero on fault or write |
| rsp_fault | output | 2 | 00 none, 01 range, 10 alignment |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 4 | RAM byte-lane write enables |
| ram_addr | output | WADDR_W | RAM word address (WADDR_W = clog2(MEM_BYTES) − 2, default 21) |
| ram_wdata | output | 32 | RAM write data placed on byte lanes |
| ram_rdata | input | 32 | RAM read data, valid one clock after a read enable |

## Verification
The assertions assume three things about the inputs. The RAM returns ram_rdata one clock after a read enable. big_endian changes only while no response is pending. req_size and req_addr are known whenever req_valid is high. The stimulus meets these assumptions in several ways. It uses a bench RAM model with exactly one cycle of read latency. It changes the byte order only after idle cycles. It drives every request field at every request. Random addresses cover the low kilobyte, the area just above the size limit and the top of the address space, so that all three fault outcomes and every lane offset occur under both byte orders.

// File: rtl/ckmem_pkg.sv
package ckmem_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WALT = 2'b11
    } acc_size_t;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_RANGE = 2'b01,
        FLT_ALIGN = 2'b10
    } fault_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } pstate_t;

    function automatic logic [15:0] swap16(input logic [15:0] v);
        return {v[7:0], v[15:8]};
    endfunction

    function automatic logic [31:0] swap32(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction
endpackage

// File: rtl/ckmem_check.sv
module ckmem_check
    import ckmem_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned MEM_BYTES = 32'h0080_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  acc_size_t         size,
    output fault_t            fault
);
    logic out_of_range;
    logic misaligned;

    assign out_of_range = {1'b0, addr} >= (ADDR_W+1)'(MEM_BYTES);

    always_comb begin
        unique case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = addr[0];
            SZ_WORD,
            SZ_WALT: misaligned = |addr[1:0];
            default: misaligned = 1'b0;
        endcase
    end

    // Range first, alignment second (R3)
    always_comb begin
        if (out_of_range)    fault = FLT_RANGE;
        else if (misaligned) fault = FLT_ALIGN;
        else                 fault = FLT_NONE;
    end
endmodule

// File: rtl/ckmem_wlane.sv
module ckmem_wlane
    import ckmem_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LANES = DATA_W / 8
) (
    input  acc_size_t          size,
    input  logic [1:0]         off,
    input  logic               big,
    input  logic [DATA_W-1:0]  wdata,
    output logic [LANES-1:0]   be,
    output logic [DATA_W-1:0]  lanes
);
    logic [15:0] half_ord;

    assign half_ord = big ? swap16(wdata[15:0]) : wdata[15:0];

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                be    = LANES'(1) << off;
                lanes = {LANES{wdata[7:0]}};
            end
            SZ_HALF: begin
                be    = off[1] ? 4'b1100 : 4'b0011;
                lanes = {2{half_ord}};
            end
            SZ_WORD,
            SZ_WALT: begin
                be    = '1;
                lanes = big ? swap32(wdata) : wdata;
            end
            default: begin
                be    = '0;
                lanes = '0;
            end
        endcase
    end
endmodule

// File: rtl/ckmem_rlane.sv
module ckmem_rlane
    import ckmem_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  acc_size_t          size,
    input  logic [1:0]         off,
    input  logic               big,
    input  logic [DATA_W-1:0]  raw,
    output logic [DATA_W-1:0]  value
);
    logic [7:0]  byte_sel;
    logic [15:0] half_sel;

    assign byte_sel = raw[8*off +: 8];
    assign half_sel = off[1] ? raw[31:16] : raw[15:0];

    always_comb begin
        unique case (size)
            SZ_BYTE: value = {24'd0, byte_sel};
            SZ_HALF: value = {16'd0, (big ? swap16(half_sel) : half_sel)};
            SZ_WORD,
            SZ_WALT: value = big ? swap32(raw) : raw;
            default: value = '0;
        endcase
    end
endmodule

// File: rtl/ckmem_port.sv
module ckmem_port
    import ckmem_pkg::*;
#(
    parameter int unsigned MEM_BYTES = 32'h0080_0000,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DATA_W    = 32,
    localparam int unsigned LANES    = DATA_W / 8,
    localparam int unsigned WADDR_W  = $clog2(MEM_BYTES) - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               big_endian,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         req_size,
    input  logic               req_we,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic [1:0]         rsp_fault,
    output logic               ram_en,
    output logic [LANES-1:0]   ram_we,
    output logic [WADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0]  ram_wdata,
    input  logic [DATA_W-1:0]  ram_rdata
);
    pstate_t   state_q, state_d;
    acc_size_t size_in, size_q;
    fault_t    fault_in, fault_q;
    logic [1:0] off_q;
    logic       big_q, we_q;
    logic [LANES-1:0]  lane_be;
    logic [DATA_W-1:0] lane_data;
    logic [DATA_W-1:0] gathered;
    logic              go;

    assign size_in = acc_size_t'(req_size);

    ckmem_check #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_check (
        .addr  (req_addr),
        .size  (size_in),
        .fault (fault_in)
    );

    ckmem_wlane #(.DATA_W(DATA_W)) u_wlane (
        .size  (size_in),
        .off   (req_addr[1:0]),
        .big   (big_endian),
        .wdata (req_wdata),
        .be    (lane_be),
        .lanes (lane_data)
    );

    ckmem_rlane #(.DATA_W(DATA_W)) u_rlane (
        .size  (size_q),
        .off   (off_q),
        .big   (big_q),
        .raw   (ram_rdata),
        .value (gathered)
    );

    // RAM side: driven in the request cycle, suppressed on any fault
    assign go        = req_valid && (fault_in == FLT_NONE);
    assign ram_en    = go;
    assign ram_we    = (go && req_we) ? lane_be : '0;
    assign ram_addr  = req_addr[WADDR_W+1:2];
    assign ram_wdata = lane_data;

    // Next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and captured request attributes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            size_q  <= SZ_BYTE;
            fault_q <= FLT_NONE;
            off_q   <= 2'b00;
            big_q   <= 1'b0;
            we_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                size_q  <= size_in;
                fault_q <= fault_in;
                off_q   <= req_addr[1:0];
                big_q   <= big_endian;
                we_q    <= req_we;
            end
        end
    end

    // Outputs
    always_comb begin
        rsp_valid = 1'b0;
        rsp_fault = FLT_NONE;
        rsp_rdata = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESP: begin
                rsp_valid = 1'b1;
                rsp_fault = fault_q;
                if (!we_q && fault_q == FLT_NONE)
                    rsp_rdata = gathered;
            end
            default: ;
        endcase
    end

    // Assertions
    a_r8_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r8_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r1_range_blocks_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_addr} >= (ADDR_W+1)'(MEM_BYTES))) |-> (!ram_en && ram_we == '0));
    a_r3_range_reported: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_addr} >= (ADDR_W+1)'(MEM_BYTES))) |=> (rsp_fault == FLT_RANGE));
    a_r2_byte_never_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == SZ_BYTE) |=> (rsp_fault != FLT_ALIGN));
    a_r7_fault_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_rdata == '0));
    a_r9_byte_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we != '0 && req_size == SZ_BYTE) |-> ($countones(ram_we) == 1));
    a_r10_we_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we != '0) |-> ram_en);
endmodule

// File: tb/sim_ckmem_port.sv
module sim_ckmem_port;
    localparam int unsigned MEM = 32'h0080_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big_endian = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_we = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [1:0]  rsp_fault;
    logic        ram_en;
    logic [3:0]  ram_we;
    logic [20:0] ram_addr;
    logic [31:0] ram_wdata;
    logic [31:0] ram_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ckmem_port u0 (
        .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
        .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
        .req_we(req_we), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // Bench RAM: 256 words, one-cycle read latency
    logic [31:0] bram [0:255];
    initial for (int i = 0; i < 256; i++) bram[i] = '0;
    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we == 4'b0000) ram_rdata <= bram[ram_addr[7:0]];
            for (int k = 0; k < 4; k++)
                if (ram_we[k]) bram[ram_addr[7:0]][8*k +: 8] <= ram_wdata[8*k +: 8];
        end
    end

    // Reference model: byte memory of 1 KiB
    logic [7:0] rm [0:1023];
    initial for (int i = 0; i < 1024; i++) rm[i] = '0;

    bit          exp_valid = 0;
    logic [1:0]  exp_fault = '0;
    logic [31:0] exp_data = '0;
    string       exp_tag = "R8";

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_rsp();
        check("R8 rsp_valid", {31'd0, rsp_valid}, {31'd0, exp_valid});
        if (exp_valid) begin
            check({exp_tag, " fault"}, {30'd0, rsp_fault}, {30'd0, exp_fault});
            check({exp_tag, " data"}, rsp_rdata, exp_data);
        end
    endtask

    // One request per cycle, driven and checked at the falling edge
    task automatic issue(input bit v, input logic [31:0] a, input logic [1:0] sz,
                         input bit we, input logic [31:0] wd);
        logic [1:0]  f;
        logic [3:0]  ebe;
        logic [31:0] d;
        int n;
        int base;
        compare_rsp();
        req_valid = v; req_addr = a; req_size = sz; req_we = we; req_wdata = wd;
        #1;
        exp_valid = v;
        if (!v) begin
            check("R10 idle ram_en", {31'd0, ram_en}, 32'd0);
        end else begin
            n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
            if (a >= MEM) f = 2'b01;
            else if ((n == 4 && a[1:0] != 2'b00) || (n == 2 && a[0])) f = 2'b10;
            else f = 2'b00;
            exp_fault = f;
            exp_data = '0;
            if (f == 2'b01) exp_tag = (a[0] && n > 1) ? "R3" : "R1";
            else if (f == 2'b10) exp_tag = "R2";
            else if (sz == 2'b11) exp_tag = "R11";
            else if (we) exp_tag = "R7";
            else if (n < 4) exp_tag = "R6";
            else exp_tag = big_endian ? "R4" : "R5";
            if (f != 2'b00) begin
                check({exp_tag, " fault blocks ram"}, {27'd0, ram_en, ram_we}, 32'd0);
            end else begin
                ebe = (n == 1) ? (4'b0001 << a[1:0]) : (n == 2) ? (a[1] ? 4'b1100 : 4'b0011) : 4'b1111;
                check("R9 lane enables", {28'd0, ram_we}, we ? {28'd0, ebe} : 32'd0);
                base = int'(a[9:0]);
                if (we) begin
                    for (int i = 0; i < n; i++)
                        rm[base + i] = big_endian ? wd[8*(n-1-i) +: 8] : wd[8*i +: 8];
                end else begin
                    d = '0;
                    for (int i = 0; i < n; i++) begin
                        if (big_endian) d = (d << 8) | {24'd0, rm[base + i]};
                        else            d = d | ({24'd0, rm[base + i]} << (8*i));
                    end
                    exp_data = d;
                end
            end
        end
        @(negedge clk);
    endtask

    function automatic logic [31:0] rand_addr();
        int r;
        r = $urandom_range(0, 9);
        if (r < 7) return {22'd0, 10'($urandom_range(0, 1023))};
        else if (r < 9) return MEM + 32'($urandom_range(0, 7));
        else return 32'hFFFF_FFF8 + 32'($urandom_range(0, 7));
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R10 reset ram_we", {27'd0, ram_en, ram_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Little-endian directed
        big_endian = 1'b0;
        issue(1, 32'h10, 2'b10, 1, 32'h1122_3344);   // word write
        issue(1, 32'h10, 2'b00, 0, 0);               // byte read: 44 (R5, R6)
        issue(1, 32'h12, 2'b01, 0, 0);               // half read: 1122
        issue(1, 32'h10, 2'b10, 0, 0);               // word read
        issue(1, 32'h21, 2'b00, 1, 32'hFFFF_FFA5);   // byte write, only [7:0] (R9)
        issue(1, 32'h20, 2'b10, 0, 0);
        issue(1, 32'h26, 2'b01, 1, 32'hDEAD_BEEF);   // half write, only [15:0]
        issue(1, 32'h24, 2'b10, 0, 0);
        issue(1, 32'h31, 2'b01, 1, 32'h5555_5555);   // misaligned half (R2)
        issue(1, 32'h32, 2'b10, 0, 0);               // misaligned word read, zero data (R7)
        issue(1, 32'h30, 2'b10, 0, 0);               // untouched by faulting write
        issue(1, MEM, 2'b00, 1, 32'h77);             // range boundary (R1)
        issue(1, MEM - 1, 2'b00, 1, 32'h66);         // last byte legal in range check
        issue(1, MEM + 3, 2'b10, 0, 0);              // range and misaligned (R3)
        issue(1, 32'h40, 2'b11, 1, 32'hCAFE_F00D);   // size 11 write (R11)
        issue(1, 32'h40, 2'b11, 0, 0);
        issue(1, 32'h42, 2'b11, 0, 0);               // size 11 misaligned
        issue(0, 0, 0, 0, 0);
        issue(0, 0, 0, 0, 0);

        // Big-endian directed
        big_endian = 1'b1;
        issue(0, 0, 0, 0, 0);
        issue(1, 32'h10, 2'b00, 0, 0);               // same bytes, other order (R4)
        issue(1, 32'h10, 2'b10, 0, 0);
        issue(1, 32'h50, 2'b10, 1, 32'h0102_0304);
        issue(1, 32'h50, 2'b00, 0, 0);               // 01
        issue(1, 32'h52, 2'b01, 0, 0);               // 0304
        issue(1, 32'h55, 2'b00, 0, 0);
        issue(0, 0, 0, 0, 0);

        // Random, both orders
        for (int ph = 0; ph < 4; ph++) begin
            big_endian = ph[0];
            issue(0, 0, 0, 0, 0);
            for (int i = 0; i < 300; i++) begin
                issue(($urandom_range(0, 7) != 0), rand_addr(), 2'($urandom_range(0, 3)),
                      1'($urandom_range(0, 1)), $urandom());
            end
            issue(0, 0, 0, 0, 0);
        end
        compare_rsp();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule